// File: doc/BRIEF.md
# Parallel Bus Transaction Sequencer

This block is a host-side master for a remote bus bridge that sits at the end of a narrow parallel link. It accepts byte, word and longword memory requests, as well as accesses to the bridge's status register, on a request/acknowledge interface. Each memory request is serialised over one 16-bit shared bus in strobe-latched phases. A 3-bit command code on the link tells the bridge what kind of transaction is running.

A memory access sends the 24-bit address in two halves. Each half is latched by a pulse on the active-low write strobe. A write then sends a third phase carrying the data word, releases the bus, and waits until the bridge pulls the ready line low. A read releases the bus, holds the active-low read strobe down until ready goes high, and captures the word. Longwords are split into two word accesses. Byte accesses steer their lane from address bit 0.

Status register accesses are short and run at fixed length, with no handshake. When the bridge pulls its interrupt line low, the sequencer polls the status register on its own and presents the top three bits as an interrupt priority level.

Top module: `bus_txn_seq`

## Requirements
- R1: After a synchronous active-high reset the sequencer is idle: both strobes high, `cmd` = 000, the bus released (`bus_oe` = 0), `ack` = 0 and `ipl` = 0.
- R2: `cmd` carries the transaction code for the whole transaction: word write 000, word read 001, byte write 010, byte read 011, status access 100. It returns to 000 when idle.
- R3: A memory access begins with two address phases, each one cycle with `wr_n` low and one with `wr_n` high while the bus is driven. The first phase carries address bits 15:0. The second carries bits 23:16 on bus bits 7:0, with zeros above. The request address is masked to 24 bits.
- R4: A memory write adds a third phase carrying the data word, then releases the bus. It stays waiting while `rdy` is high and ends one cycle after `rdy` is seen low.
- R5: A memory read releases the bus after the address phases and holds `rd_n` low until `rdy` is seen high. It captures `bus_in` at that edge and raises `rd_n` in the next cycle, which is also the acknowledge cycle.
- R6: A byte write to an even address drives the byte on both bus halves. A byte write to an odd address drives it on bits 7:0, with bits 15:8 zero.
- R7: A byte read returns, zero-extended in `rdata`, bits 15:8 of the captured word for an even address and bits 7:0 for an odd address.
- R8: A longword access is two word accesses. The first carries bits 31:16 at the given address and the second carries bits 15:0 at the address plus 2, modulo 2^24. A longword read returns the first word in `rdata[31:16]`.
- R9: A status write has no address phase: it drives the data word for four cycles, `wr_n` low for the first two and high for the last two, ignores `rdy`, and acknowledges in the fifth cycle after acceptance.
- R10: A status read releases the bus and holds `rd_n` low for exactly four cycles, ignoring `rdy`. It captures `bus_in` at the end of the fourth cycle and acknowledges in the fifth, with the word in `rdata[15:0]`.
- R11: While idle with no request and `irq_n` low, the sequencer runs a status read without acknowledging it and loads `ipl` with bits 15:13 of the captured word. A pending request takes priority over the poll. `ipl` clears to 0 whenever the sequencer is idle and `irq_n` is high.
- R12: A request is accepted only when idle, and its fields are latched at acceptance. `ack` is a one-cycle pulse. The bus is never driven while `rd_n` is low, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when the sequencer is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword (3 is treated as word) |
| req_status | input | 1 | Access the status register instead of memory |
| req_addr | input | 32 | Byte address; only the low 24 bits are used |
| req_wdata | input | 32 | Write data (byte in 7:0, word in 15:0) |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with `ack` |
| cmd | output | 3 | Transaction code to the bridge |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus output enable; 0 means released |
| bus_in | input | 16 | Value seen on the shared bus |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |
| rdy | input | 1 | Bridge ready handshake |
| irq_n | input | 1 | Active-low interrupt request from the bridge |
| ipl | output | 3 | Interrupt priority level read from the status register |

## Verification
The assertions assume that `rdy` eventually settles to the level each wait state looks for. They also assume that `irq_n` and the request fields are synchronous to `clk` and stable around the rising edge. The bench changes every input only on the falling edge. It releases `rdy` at chosen cycle counts so that the waits always end, and it holds reset long enough that every look into the past sees the idle state. It deliberately sets `rdy` to the level that would stall a handshake during status accesses, and changes the request fields while a transaction is running, so that what the sequencer ignores is shown at its ports.

// File: rtl/bus_txn_seq.sv
`timescale 1ns/1ps
module bus_txn_seq #(
  parameter int ADDR_W    = 24,
  parameter int SR_RD_CYC = 4,
  parameter int SR_WR_LO  = 2,
  parameter int SR_WR_HI  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_status,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output logic [2:0]  cmd,
  output logic [15:0] bus_out,
  output logic        bus_oe,
  input  logic [15:0] bus_in,
  output logic        wr_n,
  output logic        rd_n,
  input  logic        rdy,
  input  logic        irq_n,
  output logic [2:0]  ipl
);
  localparam int SR_WR_CYC = SR_WR_LO + SR_WR_HI;
  localparam int CNT_MAX   = (SR_RD_CYC > SR_WR_CYC) ? SR_RD_CYC : SR_WR_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_LONG = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_AL0, S_AL1, S_AH0, S_AH1, S_D0, S_D1,
    S_WWAIT, S_RWAIT, S_SW, S_SR, S_DONE
  } state_t;

  state_t            state;
  logic              op_wr, op_byte, op_long, op_stat, op_poll, half;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rbuf;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic [31:0]       addr_ext;
  logic [15:0]       wword;
  logic              last_word;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^req_addr[31:ADDR_W];
  assign cur_addr  = half ? addr + ADDR_W'(2) : addr;
  assign addr_ext  = 32'(cur_addr);
  assign last_word = !op_long || half;

  always_comb begin
    if (op_stat)      wword = wdata[15:0];
    else if (op_byte) wword = cur_addr[0] ? {8'h00, wdata[7:0]} : {2{wdata[7:0]}};
    else if (op_long) wword = half ? wdata[15:0] : wdata[31:16];
    else              wword = wdata[15:0];
  end

  always_comb begin
    if (state == S_IDLE) cmd = 3'b000;
    else if (op_stat)    cmd = 3'b100;
    else                 cmd = {1'b0, op_byte, !op_wr};
  end

  always_comb begin
    case (state)
      S_AL0, S_AL1:     bus_out = addr_ext[15:0];
      S_AH0, S_AH1:     bus_out = addr_ext[31:16];
      S_D0, S_D1, S_SW: bus_out = wword;
      default:          bus_out = 16'h0000;
    endcase
  end

  assign bus_oe = (state == S_AL0) || (state == S_AL1) || (state == S_AH0) ||
                  (state == S_AH1) || (state == S_D0)  || (state == S_D1)  ||
                  (state == S_SW);
  assign wr_n   = !((state == S_AL0) || (state == S_AH0) || (state == S_D0) ||
                    ((state == S_SW) && (cnt < CNT_W'(SR_WR_LO))));
  assign rd_n   = !((state == S_RWAIT) || (state == S_SR));
  assign ack    = (state == S_DONE) && !op_poll;
  assign rdata  = rbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op_wr   <= 1'b0;
      op_byte <= 1'b0;
      op_long <= 1'b0;
      op_stat <= 1'b0;
      op_poll <= 1'b0;
      half    <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      cnt     <= '0;
      rbuf    <= '0;
      ipl     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (irq_n) ipl <= '0;
          cnt  <= '0;
          half <= 1'b0;
          if (req_valid) begin
            op_wr   <= req_write;
            op_stat <= req_status;
            op_poll <= 1'b0;
            op_byte <= !req_status && (req_size == SZ_BYTE);
            op_long <= !req_status && (req_size == SZ_LONG);
            addr    <= req_addr[ADDR_W-1:0];
            wdata   <= req_wdata;
            state   <= req_status ? (req_write ? S_SW : S_SR) : S_AL0;
          end else if (!irq_n) begin
            op_wr   <= 1'b0;
            op_stat <= 1'b1;
            op_poll <= 1'b1;
            op_byte <= 1'b0;
            op_long <= 1'b0;
            state   <= S_SR;
          end
        end
        S_AL0: state <= S_AL1;
        S_AL1: state <= S_AH0;
        S_AH0: state <= S_AH1;
        S_AH1: state <= op_wr ? S_D0 : S_RWAIT;
        S_D0:  state <= S_D1;
        S_D1:  state <= S_WWAIT;
        S_WWAIT: begin
          if (!rdy) begin
            half  <= 1'b1;
            state <= last_word ? S_DONE : S_AL0;
          end
        end
        S_RWAIT: begin
          if (rdy) begin
            if (op_byte)      rbuf <= {24'h0, cur_addr[0] ? bus_in[7:0] : bus_in[15:8]};
            else if (!op_long) rbuf <= {16'h0, bus_in};
            else if (half)    rbuf[15:0] <= bus_in;
            else              rbuf[31:16] <= bus_in;
            half  <= 1'b1;
            state <= last_word ? S_DONE : S_AL0;
          end
        end
        S_SW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(SR_WR_CYC - 1)) state <= S_DONE;
        end
        S_SR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(SR_RD_CYC - 1)) begin
            if (op_poll) ipl  <= bus_in[15:13];
            else         rbuf <= {16'h0, bus_in};
            state <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_rd_no_drive_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_oe && !rd_n));
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && !rd_n));
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(cmd));
  p_wr_drives_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> bus_oe);
  p_wr_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_WWAIT && rdy) |=> (state == S_WWAIT && !bus_oe && wr_n));
  p_rd_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_RWAIT && !rdy) |=> (state == S_RWAIT && !rd_n));
  p_sw_low_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(wr_n) && state == S_SW) |=> !wr_n);
  p_ipl_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && irq_n) |=> (ipl == 3'd0));
endmodule

// File: tb/bus_txn_seq_bench.sv
`timescale 1ns/1ps
module bus_txn_seq_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_status = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic ack, bus_oe, wr_n, rd_n;
  logic [31:0] rdata;
  logic [2:0] cmd, ipl;
  logic [15:0] bus_out;
  logic [15:0] bus_in = 16'h0;
  logic rdy = 1'b0, irq_n = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [15:0] log_val [8];
  logic [2:0]  log_cmd [8];
  int n_lat = 0, wr_low = 0, rd_low = 0;
  logic prev_wr = 1'b1;
  logic [15:0] lv;
  logic [2:0]  lc;
  int r_lat;
  logic [31:0] r_data;
  logic [2:0]  r_cmd;

  bus_txn_seq u_bus_txn_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_status(req_status), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .cmd(cmd),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .wr_n(wr_n),
    .rd_n(rd_n), .rdy(rdy), .irq_n(irq_n), .ipl(ipl)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!wr_n) begin
        lv = bus_out;
        lc = cmd;
        wr_low++;
      end else if (!prev_wr && n_lat < 8) begin
        log_val[n_lat] = lv;
        log_cmd[n_lat] = lc;
        n_lat++;
      end
      if (!rd_n) rd_low++;
      prev_wr = wr_n;
    end
  end

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic w, input logic [1:0] sz, input logic st,
                     input logic [31:0] a, input logic [31:0] d, input logic rdy0,
                     input int flip, input bit hold, input int sw_at,
                     input logic [15:0] bin2);
    n_lat = 0; wr_low = 0; rd_low = 0;
    rdy = rdy0;
    req_write = w; req_size = sz; req_status = st; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    r_lat = 0;
    while (r_lat < 300) begin
      @(negedge clk);
      r_lat++;
      if (!hold) req_valid = 1'b0;
      else begin
        req_addr  = 32'h00FF_FFFE;
        req_wdata = 32'h0;
      end
      if (r_lat == flip)  rdy = !rdy0;
      if (r_lat == sw_at) bus_in = bin2;
      if (ack) break;
    end
    r_data = rdata;
    r_cmd  = cmd;
    req_valid = 1'b0;
    @(negedge clk);
    chk_eq("R12 ack lasts one cycle", {31'h0, ack}, 32'h0);
  endtask

  task automatic t_reset;
    chk_eq("R1 wr_n", {31'h0, wr_n}, 32'h1);
    chk_eq("R1 rd_n", {31'h0, rd_n}, 32'h1);
    chk_eq("R1 cmd", {29'h0, cmd}, 32'h0);
    chk_eq("R1 bus_oe", {31'h0, bus_oe}, 32'h0);
    chk_eq("R1 ack", {31'h0, ack}, 32'h0);
    chk_eq("R1 ipl", {29'h0, ipl}, 32'h0);
  endtask

  task automatic t_word_write;
    run(1, 2'd1, 0, 32'hAB12_3456, 32'h0000_BEEF, 1, 10, 0, 0, 16'h0);
    chk_eq("R4 write waits for rdy low", r_lat, 11);
    chk_eq("R4 three phases", n_lat, 3);
    chk_eq("R3 low address phase", {16'h0, log_val[0]}, 32'h3456);
    chk_eq("R3 high address masked", {16'h0, log_val[1]}, 32'h0012);
    chk_eq("R4 data phase", {16'h0, log_val[2]}, 32'hBEEF);
    chk_eq("R2 word write code", {29'h0, log_cmd[0]}, 32'h0);
    chk_eq("R3 one low cycle per phase", wr_low, 3);
    run(1, 2'd1, 0, 32'h0000_0010, 32'h0000_1234, 0, 0, 0, 0, 16'h0);
    chk_eq("R4 ready already low", r_lat, 8);
  endtask

  task automatic t_word_read;
    bus_in = 16'h1234;
    run(0, 2'd1, 0, 32'h0000_0F00, 32'h0, 0, 7, 0, 0, 16'h0);
    chk_eq("R5 read latency", r_lat, 8);
    chk_eq("R5 read data", r_data, 32'h0000_1234);
    chk_eq("R5 rd_n low until ready", rd_low, 3);
    chk_eq("R2 word read code", {29'h0, r_cmd}, 32'h1);
    chk_eq("R3 read address phases", n_lat, 2);
    chk_eq("R3 read low address", {16'h0, log_val[0]}, 32'h0F00);
  endtask

  task automatic t_byte_write;
    run(1, 2'd0, 0, 32'h0000_0010, 32'h0000_005A, 0, 0, 0, 0, 16'h0);
    chk_eq("R6 even byte both lanes", {16'h0, log_val[2]}, 32'h5A5A);
    chk_eq("R2 byte write code", {29'h0, log_cmd[2]}, 32'h2);
    run(1, 2'd0, 0, 32'h0000_0011, 32'h0000_005A, 0, 0, 0, 0, 16'h0);
    chk_eq("R6 odd byte low lane", {16'h0, log_val[2]}, 32'h005A);
  endtask

  task automatic t_byte_read;
    bus_in = 16'hC3A5;
    run(0, 2'd0, 0, 32'h0000_0020, 32'h0, 0, 5, 0, 0, 16'h0);
    chk_eq("R7 even byte upper half", r_data, 32'h0000_00C3);
    chk_eq("R2 byte read code", {29'h0, r_cmd}, 32'h3);
    chk_eq("R7 byte read latency", r_lat, 6);
    run(0, 2'd0, 0, 32'h0000_0021, 32'h0, 0, 5, 0, 0, 16'h0);
    chk_eq("R7 odd byte lower half", r_data, 32'h0000_00A5);
  endtask

  task automatic t_long;
    run(1, 2'd2, 0, 32'h0000_FFFE, 32'h1122_3344, 0, 0, 0, 0, 16'h0);
    chk_eq("R8 long write latency", r_lat, 15);
    chk_eq("R8 six phases", n_lat, 6);
    chk_eq("R8 first data upper", {16'h0, log_val[2]}, 32'h1122);
    chk_eq("R8 second address low", {16'h0, log_val[3]}, 32'h0000);
    chk_eq("R8 second address carry", {16'h0, log_val[4]}, 32'h0001);
    chk_eq("R8 second data lower", {16'h0, log_val[5]}, 32'h3344);
    bus_in = 16'h1111;
    run(0, 2'd2, 0, 32'h0040_0200, 32'h0, 1, 0, 0, 6, 16'h2222);
    chk_eq("R8 long read data", r_data, 32'h1111_2222);
    chk_eq("R8 long read latency", r_lat, 11);
    chk_eq("R8 long read second address", {16'h0, log_val[2]}, 32'h0202);
  endtask

  task automatic t_status;
    run(1, 2'd1, 1, 32'h0000_0000, 32'h0000_8421, 1, 0, 0, 0, 16'h0);
    chk_eq("R9 status write ignores rdy", r_lat, 5);
    chk_eq("R9 single phase", n_lat, 1);
    chk_eq("R9 data value", {16'h0, log_val[0]}, 32'h8421);
    chk_eq("R9 strobe low two cycles", wr_low, 2);
    chk_eq("R2 status code", {29'h0, log_cmd[0]}, 32'h4);
    bus_in = 16'h6006;
    run(0, 2'd1, 1, 32'h0, 32'h0, 0, 0, 0, 0, 16'h0);
    chk_eq("R10 status read latency", r_lat, 5);
    chk_eq("R10 status data", r_data, 32'h0000_6006);
    chk_eq("R10 rd_n low four cycles", rd_low, 4);
    chk_eq("R10 no address phase", n_lat, 0);
    chk_eq("R2 status read code", {29'h0, r_cmd}, 32'h4);
  endtask

  task automatic t_irq;
    int acks = 0;
    bus_in = 16'hA000;
    irq_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ack) acks++;
    end
    chk_eq("R11 ipl from status bits", {29'h0, ipl}, 32'h5);
    chk_eq("R11 poll not acknowledged", acks, 0);
    irq_n = 1'b1;
    repeat (10) @(negedge clk);
    chk_eq("R11 ipl cleared", {29'h0, ipl}, 32'h0);
  endtask

  task automatic t_priority;
    bus_in = 16'h4321;
    irq_n = 1'b0;
    run(0, 2'd1, 0, 32'h0000_0100, 32'h0, 0, 5, 0, 0, 16'h0);
    chk_eq("R11 request beats poll", r_lat, 6);
    chk_eq("R11 request data", r_data, 32'h0000_4321);
    irq_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_busy;
    run(1, 2'd1, 0, 32'h0000_0100, 32'h0000_0F0F, 0, 0, 1, 0, 16'h0);
    chk_eq("R12 address latched", {16'h0, log_val[0]}, 32'h0100);
    chk_eq("R12 data latched", {16'h0, log_val[2]}, 32'h0F0F);
    chk_eq("R12 busy request ignored", r_lat, 8);
    repeat (3) @(negedge clk);
    chk_eq("R12 no second transaction", {31'h0, bus_oe}, 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_word_write;
    t_word_read;
    t_byte_write;
    t_byte_read;
    t_long;
    t_status;
    t_irq;
    t_priority;
    t_busy;
    summary;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    summary;
    $finish;
  end
endmodule